// File: doc/BRIEF.md
# Indexed Clock-Chip Host Register Port

This block is the host side of a real-time clock. The host sees two byte addresses. A write at the even address selects one of 128 register slots. An access at the odd address reads or writes the selected slot. Most slots are plain byte storage. The time fields and alarm fields live in these slots.

Four slots are control registers that the block implements itself. Control A holds an update-in-progress flag. Control B holds the mode and interrupt-enable bits. Control C holds the interrupt flags and is cleared when it is read. Control D is a constant status byte.

Event strobes come in from three neighbours: the periodic rate divider, the alarm comparator and the update-cycle sequencer. The block turns them into flags and into a level interrupt request. Toward the calendar counter it sends only a one-cycle reload request. Each request means that the calendar must take its value from the time slots again.

Top module: `rtc_host_regs`

## Requirements
- R1: A write at address 0 (`addr_i` low) stores the low 7 bits of `wdata_i` as the slot index. A read at address 0 returns 0xFF.
- R2: A write at address 1 updates the slot at the current index, and a later read at address 1 returns that byte. This applies to every index except 10 to 13.
- R3: Writes to slot 10 (control A) replace bits 6:0 and keep bit 7, the update-in-progress flag. Bit 7 is set by `upd_start_i` while the set bit (bit 7 of B) is clear. Bit 7 is cleared by `upd_end_i`.
- R4: Writing slot 11 (control B) with bit 7 high clears bit 7 of A. It also stores bit 4 (update-ended enable) as 0. While B bit 7 is high, A bit 7 stays 0.
- R5: `reload_o` pulses for one cycle, in the cycle after either of two writes. The first is a write to a time slot (0, 2, 4, 6, 7, 8, 9) while B bit 7 is clear. The second is a write to B that clears a previously set bit 7. Writes to alarm slots (1, 3, 5) never request a reload.
- R6: Slots 12 and 13 ignore writes. Slot 13 always reads 0x80.
- R7: A periodic strobe sets C bits 7 and 6 (0xC0) only when B bit 6 is set. Otherwise it has no effect.
- R8: An alarm strobe sets C bits 7 and 5 (0xA0) only when B bit 5 is set.
- R9: An update-end strobe always sets C bit 4. It also sets C bit 7 only when B bit 4 is set.
- R10: `irq_o` equals C bit 7. A read of slot 12 returns C, then clears C and drops `irq_o`. A strobe in the same cycle as the read still sets its flags.
- R11: After reset, A=0x26, B=0x02, C=0x00, D=0x80, `irq_o`=0 and `reload_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Host access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = index port, 1 = data port |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, combinational for the current access |
| periodic_evt_i | input | 1 | Periodic divider tick |
| alarm_evt_i | input | 1 | Alarm comparator match |
| upd_start_i | input | 1 | Update cycle begins |
| upd_end_i | input | 1 | Update cycle ends |
| reload_o | output | 1 | Calendar reload request pulse |
| irq_o | output | 1 | Interrupt request, level |

## Verification
Each event strobe is applied twice, once with its enable bit clear and once with it set. This separates the flag that always sets (update-ended) from the gated ones. The read-to-clear path is tried alone and also together with a same-cycle strobe, which tells a clear-wins design from a set-wins one. Set mode is entered and left around writes to time and alarm slots, so reload pulses that are missing or spurious show up. Control A is written while the update flag is both high and low, to show that host writes never touch it.

// File: rtl/rtc_idx_pkg.sv
package rtc_idx_pkg;
  localparam int unsigned SLOT_A = 10;
  localparam int unsigned SLOT_B = 11;
  localparam int unsigned SLOT_C = 12;
  localparam int unsigned SLOT_D = 13;

  localparam int unsigned B_SET = 7;
  localparam int unsigned B_PIE = 6;
  localparam int unsigned B_AIE = 5;
  localparam int unsigned B_UIE = 4;

  localparam int unsigned C_IRQ = 7;
  localparam int unsigned C_PF  = 6;
  localparam int unsigned C_AF  = 5;
  localparam int unsigned C_UF  = 4;

  localparam logic [7:0] RST_A = 8'h26;
  localparam logic [7:0] RST_B = 8'h02;
  localparam logic [7:0] VAL_D = 8'h80;

  function automatic logic is_time_slot(input int unsigned s);
    return (s == 0) || (s == 2) || (s == 4) || (s == 6) ||
           (s == 7) || (s == 8) || (s == 9);
  endfunction

  function automatic logic is_ctl_slot(input int unsigned s);
    return (s >= SLOT_A) && (s <= SLOT_D);
  endfunction
endpackage

// File: rtl/host_index.sv
module host_index #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [IDX_W-1:0] d_i,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_o <= '0;
    else if (ld_i) idx_o <= d_i;
  end
endmodule

// File: rtl/byte_store.sv
module byte_store #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import rtc_idx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_a_i,
  input  logic       wr_b_i,
  input  logic       wr_time_i,
  input  logic [7:0] wdata_i,
  input  logic       upd_start_i,
  input  logic       upd_end_i,
  output logic [7:0] a_o,
  output logic [7:0] b_o,
  output logic       reload_o
);
  logic [6:0] a_low_q;
  logic       uip_q, uip_d;
  logic [7:0] b_q;
  logic       reload_q, reload_d;

  // uip priority: entering set mode > update end > update start
  always_comb begin
    uip_d = uip_q;
    if (upd_start_i && !b_q[B_SET]) uip_d = 1'b1;
    if (upd_end_i)                  uip_d = 1'b0;
    if (wr_b_i && wdata_i[B_SET])   uip_d = 1'b0;
  end

  always_comb begin
    reload_d = 1'b0;
    if (wr_time_i && !b_q[B_SET])                    reload_d = 1'b1;
    if (wr_b_i && !wdata_i[B_SET] && b_q[B_SET])     reload_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_low_q  <= RST_A[6:0];
      uip_q    <= RST_A[7];
      b_q      <= RST_B;
      reload_q <= 1'b0;
    end else begin
      uip_q    <= uip_d;
      reload_q <= reload_d;
      if (wr_a_i) a_low_q <= wdata_i[6:0];
      if (wr_b_i) begin
        b_q        <= wdata_i;
        b_q[B_UIE] <= wdata_i[B_UIE] & ~wdata_i[B_SET];
      end
    end
  end

  assign a_o      = {uip_q, a_low_q};
  assign b_o      = b_q;
  assign reload_o = reload_q;

  AST_UIP_HELD_ON_A_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a_i && !wr_b_i && !upd_start_i && !upd_end_i) |=> (a_o[7] == $past(a_o[7]))); // R3
  AST_SET_DROPS_UIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_o[B_SET] |-> !b_o[B_UIE]); // R4
  AST_NO_UIP_IN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_o[B_SET] |-> !a_o[7]); // R4
  AST_NO_RELOAD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_time_i && !wr_b_i) |=> !reload_o); // R5
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import rtc_idx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] ctl_b_i,
  input  logic       periodic_i,
  input  logic       alarm_i,
  input  logic       upd_end_i,
  input  logic       rd_clr_i,
  output logic [7:0] c_o,
  output logic       irq_o
);
  logic [7:0] c_q, set_mask;

  always_comb begin
    set_mask = '0;
    if (periodic_i && ctl_b_i[B_PIE]) begin
      set_mask[C_IRQ] = 1'b1;
      set_mask[C_PF]  = 1'b1;
    end
    if (alarm_i && ctl_b_i[B_AIE]) begin
      set_mask[C_IRQ] = 1'b1;
      set_mask[C_AF]  = 1'b1;
    end
    if (upd_end_i) begin
      set_mask[C_UF] = 1'b1;
      if (ctl_b_i[B_UIE]) set_mask[C_IRQ] = 1'b1;
    end
  end

  // same-cycle set beats clear-on-read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) c_q <= '0;
    else         c_q <= (rd_clr_i ? 8'h00 : c_q) | set_mask;
  end

  assign c_o   = c_q;
  assign irq_o = c_q[C_IRQ];

  AST_READ_CLEARS_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !periodic_i && !alarm_i && !upd_end_i) |=> (c_o == 8'h00 && !irq_o)); // R10
  AST_UF_ALWAYS_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_end_i |=> c_o[C_UF]); // R9
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (c_o[C_PF] || c_o[C_AF] || c_o[C_UF])); // R7
  AST_PF_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!c_o[C_PF] && !ctl_b_i[B_PIE]) |=> !c_o[C_PF]); // R7
endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
  import rtc_idx_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              periodic_evt_i,
  input  logic              alarm_evt_i,
  input  logic              upd_start_i,
  input  logic              upd_end_i,
  output logic              reload_o,
  output logic              irq_o
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] store_rd, a_val, b_val, c_val;
  logic              dat_wr, dat_rd, sel_ctl, sel_time;
  int unsigned       idx_n;

  assign idx_n    = int'(idx);
  assign dat_wr   = cs_i && addr_i && we_i;
  assign dat_rd   = cs_i && addr_i && !we_i;
  assign sel_ctl  = is_ctl_slot(idx_n);
  assign sel_time = is_time_slot(idx_n);

  host_index #(.IDX_W(IDX_W)) u_idx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (cs_i && !addr_i && we_i),
    .d_i   (wdata_i[IDX_W-1:0]),
    .idx_o (idx)
  );

  byte_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (dat_wr && !sel_ctl),
    .addr_i (idx),
    .wdata_i(wdata_i),
    .rdata_o(store_rd)
  );

  ctrl_regs u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_a_i     (dat_wr && idx_n == SLOT_A),
    .wr_b_i     (dat_wr && idx_n == SLOT_B),
    .wr_time_i  (dat_wr && sel_time),
    .wdata_i    (wdata_i),
    .upd_start_i(upd_start_i),
    .upd_end_i  (upd_end_i),
    .a_o        (a_val),
    .b_o        (b_val),
    .reload_o   (reload_o)
  );

  flag_reg u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_b_i   (b_val),
    .periodic_i(periodic_evt_i),
    .alarm_i   (alarm_evt_i),
    .upd_end_i (upd_end_i),
    .rd_clr_i  (dat_rd && idx_n == SLOT_C),
    .c_o       (c_val),
    .irq_o     (irq_o)
  );

  always_comb begin
    if (!addr_i) rdata_o = '1;
    else begin
      unique case (idx_n)
        SLOT_A:  rdata_o = a_val;
        SLOT_B:  rdata_o = b_val;
        SLOT_C:  rdata_o = c_val;
        SLOT_D:  rdata_o = VAL_D;
        default: rdata_o = store_rd;
      endcase
    end
  end

  AST_INDEX_PORT_READS_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && !addr_i) |-> (rdata_o == 8'hFF)); // R1
  AST_D_CONSTANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_rd && idx_n == SLOT_D) |-> (rdata_o == 8'h80)); // R6
  AST_C_IGNORES_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && idx_n == SLOT_C && !periodic_evt_i && !alarm_evt_i && !upd_end_i)
      |=> (c_val == $past(c_val))); // R6
endmodule

// File: tb/sim_rtc_host_regs.sv
`timescale 1ns/1ps
module sim_rtc_host_regs;
  logic clk = 0, rst_n = 0;
  logic cs = 0, we = 0, ad = 0;
  logic [7:0] wd = 0;
  logic [7:0] rd;
  logic pe = 0, ae = 0, us = 0, ue = 0;
  logic reload, irq;

  always #2.5 clk = ~clk;

  rtc_host_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(ad),
    .wdata_i(wd), .rdata_o(rd), .periodic_evt_i(pe), .alarm_evt_i(ae),
    .upd_start_i(us), .upd_end_i(ue), .reload_o(reload), .irq_o(irq)
  );

  int n_cmp = 0, n_bad = 0;
  int m_mem [128];
  int m_idx = 0, m_a = 'h26, m_b = 'h02, m_c = 0, m_rel = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_read();
    if (!ad) return 'hFF;
    case (m_idx)
      10: return m_a;
      11: return m_b;
      12: return m_c;
      13: return 'h80;
      default: return m_mem[m_idx];
    endcase
  endfunction

  // one clock: drive, compare read data, clock, step model, compare outputs
  task automatic cyc(input bit c, input bit w, input bit a, input int d,
                     input bit p, input bit al, input bit s, input bit e,
                     input string req);
    int set_m, nb, na, rel, old_b;
    @(negedge clk);
    cs = c; we = w; ad = a; wd = 8'(d); pe = p; ae = al; us = s; ue = e;
    #1;
    if (c && !w) chk(req, rd, m_read());
    @(posedge clk);
    old_b = m_b;
    set_m = 0;
    if (p && (old_b & 'h40)) set_m |= 'hC0;
    if (al && (old_b & 'h20)) set_m |= 'hA0;
    if (e) begin set_m |= 'h10; if (old_b & 'h10) set_m |= 'h80; end
    na = m_a; nb = m_b; rel = 0;
    if (s && !(old_b & 'h80)) na |= 'h80;
    if (e) na &= 'h7F;
    if (c && !a && w) m_idx = d & 'h7F;
    if (c && a && w) begin
      case (m_idx)
        10: na = (na & 'h80) | (d & 'h7F);
        11: if (d & 'h80) begin na &= 'h7F; nb = d & 'hEF; end
            else begin if (old_b & 'h80) rel = 1; nb = d; end
        12, 13: ;
        0, 2, 4, 6, 7, 8, 9: begin m_mem[m_idx] = d & 'hFF; if (!(old_b & 'h80)) rel = 1; end
        default: m_mem[m_idx] = d & 'hFF;
      endcase
    end
    m_c = ((c && a && !w && m_idx == 12) ? 0 : m_c) | set_m;
    m_a = na; m_b = nb; m_rel = rel;
    #1;
    chk({req, " irq"}, irq, (m_c >> 7) & 1);
    chk({req, " reload"}, reload, m_rel);
  endtask

  task automatic idle(input string r);      cyc(0,0,0,0,0,0,0,0,r); endtask
  task automatic widx(input int i, input string r); cyc(1,1,0,i,0,0,0,0,r); endtask
  task automatic wdat(input int v, input string r); cyc(1,1,1,v,0,0,0,0,r); endtask
  task automatic rdat(input string r);      cyc(1,0,1,0,0,0,0,0,r); endtask
  task automatic rsel(input int i, input string r); widx(i, r); rdat(r); endtask
  task automatic wsel(input int i, input int v, input string r); widx(i, r); wdat(v, r); endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) m_mem[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 irq", irq, 0);
    chk("R11 reload", reload, 0);
    rst_n = 1;
    // R11 reset values
    rsel(10, "R11 A"); rsel(11, "R11 B"); rsel(12, "R11 C"); rsel(13, "R11 D");
    // R1 index port
    cyc(1,0,0,0,0,0,0,0,"R1 even read");
    widx('h8A, "R1"); rdat("R1 index low7");
    // R2 general storage
    wsel('h40, 'h5A, "R2"); wsel('h7F, 'hC3, "R2"); wsel('h20, 'h11, "R2");
    rsel('h40, "R2 readback"); rsel('h7F, "R2 readback"); rsel('h20, "R2 readback");
    // R3 UIP read-only
    wsel(10, 'hFF, "R3"); rdat("R3 A write low");
    cyc(0,0,0,0,0,0,1,0,"R3 start"); rdat("R3 uip set");
    wdat('h00, "R3"); rdat("R3 uip kept");
    cyc(0,0,0,0,0,0,0,1,"R3 end"); rdat("R3 uip cleared");
    rsel(12, "R9 UF without UIE");
    // R4 set mode
    cyc(0,0,0,0,0,0,1,0,"R4 start");
    wsel(11, 'h92, "R4"); rdat("R4 B stored UIE=0");
    rsel(10, "R4 uip cleared");
    cyc(0,0,0,0,0,0,1,0,"R4 start in set"); rdat("R4 uip stays 0");
    // R5 reload
    wsel(0, 'h30, "R5 time write in set");
    wsel(11, 'h02, "R5 leave set");
    wsel(2, 'h45, "R5 time write");
    wsel(9, 'h24, "R5 year write");
    wsel(3, 'h10, "R5 alarm write");
    wsel(11, 'h06, "R5 B write no set");
    rsel(0, "R2 time slot"); rsel(3, "R2 alarm slot");
    // R6 C/D ignore writes
    wsel(12, 'hFF, "R6"); rdat("R6 C unchanged");
    wsel(13, 'h00, "R6"); rdat("R6 D const");
    // R7 periodic
    cyc(0,0,0,0,1,0,0,0,"R7 no PIE"); rsel(12, "R7 no flag");
    wsel(11, 'h42, "R7");
    cyc(0,0,0,0,1,0,0,0,"R7 PIE"); idle("R7 irq high");
    rsel(12, "R10 read C"); rdat("R10 cleared");
    // R8 alarm
    cyc(0,0,0,0,0,1,0,0,"R8 no AIE"); rsel(12, "R8 no flag");
    wsel(11, 'h22, "R8");
    cyc(0,0,0,0,0,1,0,0,"R8 AIE"); rsel(12, "R8 flag"); rdat("R8 cleared");
    // R9 update end
    wsel(11, 'h12, "R9");
    cyc(0,0,0,0,0,0,0,1,"R9 UIE"); rsel(12, "R9 flag+irq"); rdat("R9 cleared");
    // R10 same-cycle set wins over clear
    wsel(11, 'h42, "R10");
    cyc(0,0,0,0,1,0,0,0,"R10 arm");
    widx(12, "R10");
    cyc(1,0,1,0,1,0,0,0,"R10 read with event");
    rdat("R10 set wins");
    rdat("R10 cleared");
    repeat (3) idle("idle");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule